// File: doc/BRIEF.md
# Embedded-Operation Status Generator for a Parallel NOR Flash

This block produces the status word that a parallel NOR flash returns in place of array data while a program or erase runs inside the part. A host starts an operation with a single-cycle command strobe. While the operation runs, every read strobe (an active-low output enable plus a read address) is answered by this block. A polling bit carries the inverse of the most significant data bit being written. A general toggle bit changes on each completed read. A second toggle bit changes only for reads inside the sector whose erase is suspended. A timeout flag is raised when an operation overruns. A ready output goes low while the array is busy.

The length of each operation comes from a cycle counter set by a parameter, one for programs and one for erases. When `stat_active` is low, the surrounding logic supplies array data. When it is high, `stat_q` replaces the array data. There is no streaming data path. Commands are single-cycle pulses that are never stalled, so there is no back-pressure. A command that is not legal in the current state is dropped without effect. The error-injection input is sampled together with a program or erase command. When it is high, that operation ends in the timeout state instead of completing.

Top module: `nflash_status_gen`

## Requirements
- R1: After reset `rdy` is 1, and no read is answered with status (`stat_active` = 0).
- R2: An accepted program (`cmd_op` = 1) holds `rdy` low for exactly PROG_CYCLES clock cycles after the accepting edge, then returns to idle.
- R3: During a program, every read (with `rd_oe_n` = 0) has `stat_active` = 1 and bit 7 of `stat_q` equal to the inverse of bit 7 of the programmed data. After completion, reads are not answered with status. `stat_active` is never 1 while `rd_oe_n` is 1.
- R4: Bit 6 of `stat_q` flips once for each read strobe that ends (the rising edge of `rd_oe_n`) while the block is busy. It does not change on reads while the block is ready.
- R5: An accepted erase (`cmd_op` = 2) holds `rdy` low for ERASE_CYCLES cycles. Its status reads show bit 7 = 0, with bit 2 held steady.
- R6: A suspend (`cmd_op` = 3) during an erase raises `rdy` on the accepting edge. The remaining erase time is frozen for as long as the erase stays suspended.
- R7: While suspended, a read inside the suspended sector (address bits above SEC_LSB equal) is answered with bit 7 = 1, and bit 2 flips after each such read. A read outside that sector is not answered with status and does not flip bit 2.
- R8: A program accepted while suspended holds `rdy` low for PROG_CYCLES cycles, then returns to the suspended state. Reading its own address gives bit 2 = 1. A program aimed inside the suspended sector is dropped.
- R9: A resume (`cmd_op` = 4) continues the erase with its frozen remaining time. For a suspend accepted after W+1 counting edges, `rdy` is low for ERASE_CYCLES-1-W cycles after the resume.
- R10: An operation started with `err_inject` = 1 does not complete. When its time runs out, reads show bit 5 = 1, and `rdy` stays low until a reset command (`cmd_op` = 5) returns the block to idle.
- R11: A command that is not legal in the current state has no effect: suspend, resume or reset in idle; erase during a program; any command other than reset in the timeout state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | One-cycle command strobe |
| cmd_op | input | 3 | 1 program, 2 erase, 3 suspend, 4 resume, 5 reset |
| cmd_addr | input | AW | Program address, or any address in the sector to erase |
| cmd_data | input | DW | Data being programmed |
| err_inject | input | 1 | Sampled with program or erase; forces the timeout path |
| rd_oe_n | input | 1 | Active-low read strobe |
| rd_addr | input | AW | Read address |
| stat_active | output | 1 | Status replaces array data for this read |
| stat_q | output | DW | Status word |
| rdy | output | 1 | High when ready, low while busy |

## Verification
The status word depends combinationally on the state and the read address. The bench therefore samples it one clock after it lowers `rd_oe_n`, at the falling clock edge. A toggle flip appears only after the rising edge that follows the release of the read strobe, so the bench updates its own bit-6 and bit-2 parity models only at that point. `rdy` changes on the edge that accepts a command and on the edge where the counter expires. The bench counts falling edges from the accepting edge and expects `rdy` low on exactly the computed number of them. Busy windows are made long enough that every read completes well before the counter expires.

// File: rtl/nfs_pkg.sv
package nfs_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_PROG  = 3'd1,
    ST_ERASE = 3'd2,
    ST_SUSP  = 3'd3,
    ST_SPROG = 3'd4,
    ST_FAULT = 3'd5
  } op_state_e;

  localparam logic [2:0] OP_PROG    = 3'd1;
  localparam logic [2:0] OP_ERASE   = 3'd2;
  localparam logic [2:0] OP_SUSPEND = 3'd3;
  localparam logic [2:0] OP_RESUME  = 3'd4;
  localparam logic [2:0] OP_RESET   = 3'd5;

  localparam int POLL_BIT = 7;
  localparam int TOG_BIT  = 6;
  localparam int TMO_BIT  = 5;
  localparam int SUS_BIT  = 2;

  function automatic logic st_busy(op_state_e s);
    return (s == ST_PROG) || (s == ST_ERASE) || (s == ST_SPROG) || (s == ST_FAULT);
  endfunction

  function automatic logic st_susp(op_state_e s);
    return (s == ST_SUSP) || (s == ST_SPROG);
  endfunction

endpackage

// File: rtl/nfs_op_seq.sv
module nfs_op_seq
  import nfs_pkg::*;
#(
  parameter int AW           = 16,
  parameter int DW           = 8,
  parameter int SEC_LSB      = 12,
  parameter int PROG_CYCLES  = 500,
  parameter int ERASE_CYCLES = 20000,
  localparam int SW          = AW - SEC_LSB
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_valid,
  input  logic [2:0]      cmd_op,
  input  logic [AW-1:0]   cmd_addr,
  input  logic [DW-1:0]   cmd_data,
  input  logic            err_inject,
  output op_state_e       st,
  output logic [AW-1:0]   prog_addr,
  output logic            prog_pol,
  output logic [SW-1:0]   erase_sec,
  output logic            flt_prog
);

  localparam int PCW = $clog2(PROG_CYCLES + 1);
  localparam int ECW = $clog2(ERASE_CYCLES + 1);

  logic [PCW-1:0] pcnt;
  logic [ECW-1:0] ecnt;
  logic           perr, eerr;

  logic do_prog, do_erase, do_susp, do_resume, do_rst;
  logic prog_clash;

  assign do_prog    = cmd_valid && (cmd_op == OP_PROG);
  assign do_erase   = cmd_valid && (cmd_op == OP_ERASE);
  assign do_susp    = cmd_valid && (cmd_op == OP_SUSPEND);
  assign do_resume  = cmd_valid && (cmd_op == OP_RESUME);
  assign do_rst     = cmd_valid && (cmd_op == OP_RESET);
  assign prog_clash = (cmd_addr[AW-1:SEC_LSB] == erase_sec);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      pcnt      <= '0;
      ecnt      <= '0;
      perr      <= 1'b0;
      eerr      <= 1'b0;
      prog_addr <= '0;
      prog_pol  <= 1'b0;
      erase_sec <= '0;
      flt_prog  <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: begin
          if (do_prog) begin
            st        <= ST_PROG;
            pcnt      <= PCW'(PROG_CYCLES - 1);
            prog_addr <= cmd_addr;
            prog_pol  <= cmd_data[POLL_BIT];
            perr      <= err_inject;
          end else if (do_erase) begin
            st        <= ST_ERASE;
            ecnt      <= ECW'(ERASE_CYCLES - 1);
            erase_sec <= cmd_addr[AW-1:SEC_LSB];
            eerr      <= err_inject;
          end
        end
        ST_PROG: begin
          if (pcnt == '0) begin
            if (perr) begin
              st       <= ST_FAULT;
              flt_prog <= 1'b1;
            end else begin
              st <= ST_IDLE;
            end
          end else begin
            pcnt <= pcnt - 1'b1;
          end
        end
        ST_ERASE: begin
          if (ecnt == '0) begin
            if (eerr) begin
              st       <= ST_FAULT;
              flt_prog <= 1'b0;
            end else begin
              st <= ST_IDLE;
            end
          end else if (do_susp) begin
            st <= ST_SUSP;
          end else begin
            ecnt <= ecnt - 1'b1;
          end
        end
        ST_SUSP: begin
          if (do_resume) begin
            st <= ST_ERASE;
          end else if (do_prog && !prog_clash) begin
            st        <= ST_SPROG;
            pcnt      <= PCW'(PROG_CYCLES - 1);
            prog_addr <= cmd_addr;
            prog_pol  <= cmd_data[POLL_BIT];
            perr      <= err_inject;
          end
        end
        ST_SPROG: begin
          if (pcnt == '0) begin
            if (perr) begin
              st       <= ST_FAULT;
              flt_prog <= 1'b1;
            end else begin
              st <= ST_SUSP;
            end
          end else begin
            pcnt <= pcnt - 1'b1;
          end
        end
        ST_FAULT: begin
          if (do_rst) st <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R2: a running program cannot end before its counter reaches zero
  p_prog_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_PROG && pcnt != '0) |=> (st == ST_PROG));

  // R6: remaining erase time is frozen while suspended
  p_susp_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_SUSP) |=> $stable(ecnt));

  // R8: a program during suspend never targets the suspended sector
  p_sprog_sector_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_SPROG) |-> (prog_addr[AW-1:SEC_LSB] != erase_sec));

  // R10: the timeout state is left only through a reset command
  p_fault_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_FAULT && !do_rst) |=> (st == ST_FAULT));

endmodule

// File: rtl/nfs_toggle.sv
module nfs_toggle
  import nfs_pkg::*;
#(
  parameter int SW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_oe_n,
  input  logic [SW-1:0] rd_sec,
  input  op_state_e     st,
  input  logic [SW-1:0] erase_sec,
  output logic          tg6,
  output logic          tg2
);

  logic          oe_q;
  logic [SW-1:0] sec_q;
  logic          rd_end;

  assign rd_end = rd_oe_n && !oe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oe_q  <= 1'b1;
      sec_q <= '0;
      tg6   <= 1'b0;
      tg2   <= 1'b0;
    end else begin
      oe_q <= rd_oe_n;
      if (!rd_oe_n) sec_q <= rd_sec;
      if (rd_end && st_busy(st)) tg6 <= ~tg6;
      if (rd_end && st_susp(st) && (sec_q == erase_sec)) tg2 <= ~tg2;
    end
  end

  // R4: the general toggle moves only when a read strobe ends
  p_tg6_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_end |=> $stable(tg6));

  // R7: the sector toggle moves only for reads ending in suspend
  p_tg2_scope_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_end && st_susp(st)) |=> $stable(tg2));

endmodule

// File: rtl/nfs_status_mux.sv
module nfs_status_mux
  import nfs_pkg::*;
#(
  parameter int AW      = 16,
  parameter int DW      = 8,
  parameter int SEC_LSB = 12,
  localparam int SW     = AW - SEC_LSB
) (
  input  logic          clk,
  input  logic          rst_n,
  input  op_state_e     st,
  input  logic          rd_oe_n,
  input  logic [AW-1:0] rd_addr,
  input  logic [AW-1:0] prog_addr,
  input  logic          prog_pol,
  input  logic [SW-1:0] erase_sec,
  input  logic          flt_prog,
  input  logic          tg6,
  input  logic          tg2,
  output logic          stat_active,
  output logic [DW-1:0] stat_q
);

  logic in_sus, at_pa;
  logic          act;
  logic [DW-1:0] q;

  assign in_sus = (rd_addr[AW-1:SEC_LSB] == erase_sec);
  assign at_pa  = (rd_addr == prog_addr);

  always_comb begin
    act = 1'b0;
    q   = '0;
    case (st)
      ST_PROG: begin
        act         = 1'b1;
        q[POLL_BIT] = ~prog_pol;
        q[TOG_BIT]  = tg6;
      end
      ST_ERASE: begin
        act        = 1'b1;
        q[TOG_BIT] = tg6;
        q[SUS_BIT] = tg2;
      end
      ST_SUSP: begin
        if (in_sus) begin
          act         = 1'b1;
          q[POLL_BIT] = 1'b1;
          q[TOG_BIT]  = tg6;
          q[SUS_BIT]  = tg2;
        end
      end
      ST_SPROG: begin
        act         = 1'b1;
        q[POLL_BIT] = ~prog_pol;
        q[TOG_BIT]  = tg6;
        q[SUS_BIT]  = at_pa ? 1'b1 : (in_sus ? tg2 : 1'b0);
      end
      ST_FAULT: begin
        act         = 1'b1;
        q[POLL_BIT] = flt_prog ? ~prog_pol : 1'b0;
        q[TOG_BIT]  = tg6;
        q[TMO_BIT]  = 1'b1;
      end
      default: ;
    endcase
    if (rd_oe_n) begin
      act = 1'b0;
      q   = '0;
    end
  end

  assign stat_active = act;
  assign stat_q      = q;

  // R3: status never drives outside a read strobe
  p_oe_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    stat_active |-> !rd_oe_n);

  // R1: idle never answers with status
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE) |-> !stat_active);

endmodule

// File: rtl/nflash_status_gen.sv
module nflash_status_gen
  import nfs_pkg::*;
#(
  parameter int AW           = 16,
  parameter int DW           = 8,
  parameter int SEC_LSB      = 12,
  parameter int PROG_CYCLES  = 500,
  parameter int ERASE_CYCLES = 20000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic [2:0]    cmd_op,
  input  logic [AW-1:0] cmd_addr,
  input  logic [DW-1:0] cmd_data,
  input  logic          err_inject,
  input  logic          rd_oe_n,
  input  logic [AW-1:0] rd_addr,
  output logic          stat_active,
  output logic [DW-1:0] stat_q,
  output logic          rdy
);

  localparam int SW = AW - SEC_LSB;

  op_state_e     st;
  logic [AW-1:0] prog_addr;
  logic          prog_pol;
  logic [SW-1:0] erase_sec;
  logic          flt_prog;
  logic          tg6, tg2;

  nfs_op_seq #(
    .AW(AW), .DW(DW), .SEC_LSB(SEC_LSB),
    .PROG_CYCLES(PROG_CYCLES), .ERASE_CYCLES(ERASE_CYCLES)
  ) u_seq (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_addr(cmd_addr),
    .cmd_data(cmd_data), .err_inject(err_inject),
    .st(st), .prog_addr(prog_addr), .prog_pol(prog_pol),
    .erase_sec(erase_sec), .flt_prog(flt_prog)
  );

  nfs_toggle #(.SW(SW)) u_tog (
    .clk(clk), .rst_n(rst_n), .rd_oe_n(rd_oe_n),
    .rd_sec(rd_addr[AW-1:SEC_LSB]), .st(st), .erase_sec(erase_sec),
    .tg6(tg6), .tg2(tg2)
  );

  nfs_status_mux #(.AW(AW), .DW(DW), .SEC_LSB(SEC_LSB)) u_mux (
    .clk(clk), .rst_n(rst_n), .st(st), .rd_oe_n(rd_oe_n), .rd_addr(rd_addr),
    .prog_addr(prog_addr), .prog_pol(prog_pol), .erase_sec(erase_sec),
    .flt_prog(flt_prog), .tg6(tg6), .tg2(tg2),
    .stat_active(stat_active), .stat_q(stat_q)
  );

  assign rdy = !st_busy(st);

  // R6: a suspended erase with no program leaves the part ready
  p_susp_ready_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_SUSP) |-> rdy);

endmodule

// File: tb/sim_nflash_status_gen.sv
module sim_nflash_status_gen;

  localparam int AW = 6;
  localparam int DW = 8;
  localparam int SL = 3;
  localparam int PC = 24;
  localparam int EC = 40;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_valid = 1'b0;
  logic [2:0]    cmd_op = '0;
  logic [AW-1:0] cmd_addr = '0;
  logic [DW-1:0] cmd_data = '0;
  logic          err_inject = 1'b0;
  logic          rd_oe_n = 1'b1;
  logic [AW-1:0] rd_addr = '0;
  logic          stat_active;
  logic [DW-1:0] stat_q;
  logic          rdy;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  // bench-side models of the two toggle bits and the expected mode
  bit m6 = 0, m2 = 0, m_busy = 0, m_sus = 0;
  int m_sec = 0;

  always #10 clk = ~clk;

  nflash_status_gen #(
    .AW(AW), .DW(DW), .SEC_LSB(SL), .PROG_CYCLES(PC), .ERASE_CYCLES(EC)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data), .err_inject(err_inject),
    .rd_oe_n(rd_oe_n), .rd_addr(rd_addr),
    .stat_active(stat_active), .stat_q(stat_q), .rdy(rdy)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(int op, int addr, int data, bit err);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 3'(op); cmd_addr = AW'(addr);
    cmd_data = DW'(data); err_inject = err;
    @(negedge clk);
    cmd_valid = 1'b0; err_inject = 1'b0;
  endtask

  task automatic rd(int addr, output bit a, output logic [7:0] q);
    @(negedge clk);
    rd_oe_n = 1'b0; rd_addr = AW'(addr);
    @(negedge clk);
    a = stat_active; q = stat_q;
    rd_oe_n = 1'b1;
    if (m_busy) m6 = ~m6;
    if (m_sus && ((addr >> SL) == m_sec)) m2 = ~m2;
  endtask

  // rdy low on negedges 1..n after the accepting edge, high on n+1
  task automatic dur(string req, int n, int k0);
    for (int k = k0; k <= n + 1; k++) begin
      chk(req, rdy, (k > n) ? 1 : 0);
      if (k <= n) @(negedge clk);
    end
  endtask

  task automatic wait_rdy;
    int n = 0;
    while (!rdy && n < 5000) begin @(negedge clk); n++; end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    bit a;
    logic [7:0] q;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    chk("R1 rdy", rdy, 1);
    for (int ad = 0; ad < 64; ad += 9) begin
      rd(ad, a, q); chk("R1 active", a, 0);
    end

    // R2: exact program duration
    m_busy = 1; send(1, 5, 8'h80, 0); m_busy = 0;
    dur("R2 prog busy", PC, 1);

    // R3/R4: polling and general toggle over several data patterns
    for (int i = 0; i < 4; i++) begin
      int d;
      d = (i == 0) ? 8'h00 : (i == 1) ? 8'h7F : (i == 2) ? 8'h80 : 8'hFF;
      send(1, 11 * i + 3, d, 0);
      m_busy = 1;
      for (int j = 0; j < 6; j++) begin
        bit e6;
        e6 = m6;
        rd((7 * j + i) % 64, a, q);
        chk("R3 active", a, 1);
        chk("R3/R4 status", q, {~d[7], e6, 6'b0});
      end
      wait_rdy(); m_busy = 0;
      rd(11 * i + 3, a, q); chk("R3 done inactive", a, 0);
      rd(1, a, q);  // idle read: must not flip bit 6 (R4)
    end

    // R5: erase duration, then erase status
    send(2, 16, 0, 0);
    dur("R5 erase busy", EC, 1);
    send(2, 20, 0, 0); m_busy = 1;
    for (int j = 0; j < 8; j++) begin
      bit e6;
      e6 = m6;
      rd(9 * j, a, q);
      chk("R5 erase status", q, {1'b0, e6, 3'b0, m2, 2'b0});
    end
    wait_rdy(); m_busy = 0;
    chk("R5 rdy", rdy, 1);

    // R6: suspend after W=3 extra counting edges
    send(2, 42, 0, 0);
    repeat (3) @(negedge clk);
    send(3, 0, 0, 0);
    chk("R6 ready on suspend", rdy, 1);
    m_sus = 1; m_sec = 5;
    // R7: exhaustive address sweep while suspended
    for (int ad = 0; ad < 64; ad++) begin
      bit e6, e2;
      e6 = m6; e2 = m2;
      rd(ad, a, q);
      chk("R7 active", a, ((ad >> SL) == 5) ? 1 : 0);
      if ((ad >> SL) == 5) chk("R7 status", q, {1'b1, e6, 3'b0, e2, 2'b0});
    end
    repeat (60) @(negedge clk);
    chk("R6 still ready", rdy, 1);

    // R8: program into suspended sector is dropped
    send(1, 42, 8'h80, 0);
    chk("R8 clash dropped", rdy, 1);
    repeat (2) @(negedge clk);
    chk("R8 clash dropped later", rdy, 1);
    // R8: program elsewhere during suspend
    send(1, 10, 8'h80, 0); m_busy = 1;
    chk("R8 busy", rdy, 0);
    for (int j = 0; j < 2; j++) begin
      bit e6;
      e6 = m6; rd(10, a, q);
      chk("R8 at prog addr", q, {1'b0, e6, 3'b0, 1'b1, 2'b0});
      e6 = m6;
      begin
        bit e2;
        e2 = m2; rd(44, a, q);
        chk("R8 in sus sector", q, {1'b0, e6, 3'b0, e2, 2'b0});
      end
      e6 = m6; rd(50, a, q);
      chk("R8 elsewhere", q, {1'b0, e6, 6'b0});
    end
    wait_rdy(); m_busy = 0;
    chk("R8 back to suspend", rdy, 1);
    begin
      bit e6, e2;
      e6 = m6; e2 = m2;
      rd(41, a, q);
      chk("R8 suspended status", q, {1'b1, e6, 3'b0, e2, 2'b0});
    end

    // R9: resume finishes the remaining erase time
    send(4, 0, 0, 0); m_sus = 0;
    dur("R9 remaining erase", EC - 1 - 3, 1);
    rd(42, a, q); chk("R9 done", a, 0);

    // R10: timeout on a program
    send(1, 7, 8'h00, 1); m_busy = 1;
    repeat (PC + 6) @(negedge clk);
    chk("R10 stuck busy", rdy, 0);
    for (int j = 0; j < 3; j++) begin
      bit e6;
      e6 = m6; rd(13 * j, a, q);
      chk("R10 prog timeout", q, {1'b1, e6, 1'b1, 5'b0});
    end
    // R11: erase in timeout state dropped
    send(2, 0, 0, 0);
    begin
      bit e6;
      e6 = m6; rd(3, a, q);
      chk("R11 fault keeps", q, {1'b1, e6, 1'b1, 5'b0});
    end
    send(5, 0, 0, 0); m_busy = 0;
    chk("R10 reset ready", rdy, 1);
    rd(7, a, q); chk("R10 reset inactive", a, 0);

    // R10: timeout on an erase
    send(2, 30, 0, 1); m_busy = 1;
    repeat (EC + 5) @(negedge clk);
    chk("R10 erase stuck", rdy, 0);
    begin
      bit e6;
      e6 = m6; rd(30, a, q);
      chk("R10 erase timeout", q, {1'b0, e6, 1'b1, 5'b0});
    end
    send(5, 0, 0, 0); m_busy = 0;
    chk("R10 erase reset", rdy, 1);

    // R11: suspend/resume/reset in idle are dropped
    send(3, 0, 0, 0); chk("R11 idle suspend", rdy, 1);
    send(4, 0, 0, 0); chk("R11 idle resume", rdy, 1);
    send(5, 0, 0, 0); chk("R11 idle reset", rdy, 1);
    rd(0, a, q); chk("R11 idle inactive", a, 0);
    // R11: erase during program does not extend it
    send(1, 2, 0, 0);
    send(2, 40, 0, 0);
    dur("R11 prog unaffected", PC, 3);
    rd(40, a, q); chk("R11 no erase started", a, 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule